// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register Bank

This block is the software-visible register bank of a DRAM controller. It answers a simple 32-bit register bus that carries a byte address, write data and read data. Every access is a full word. A protection word at the bottom of the bank decides which writes are accepted. Writing one magic value opens the bank. Writing a second magic value seals it until the next reset. Writing anything else closes it again, and writes to every other word are then dropped.

Several words do not store what software writes. The configuration word keeps a version number, an aperture code and the DRAM size code in fixed fields. The PHY status word always reports that the PHY is idle and its PLL is locked. The ECC self-test word always reports a finished test that passed. This lets start-up software run its polling loops to completion without any real PHY or ECC logic behind the bank. The DRAM capacity is set by a parameter and reaches software through the configuration word.

Top module: `memctl_regbank`

## Requirements
- R1: Writing 0xFC600309 to word 0 (byte address 0x00) opens the bank; word 0 then reads 0x00000001 and writes to other words are stored.
- R2: Writing 0xDEADDEAD to word 0 seals the bank, and word 0 reads 0x00000010. Writing any other value to word 0 closes the bank, and word 0 reads 0x00000000.
- R3: While sealed, every write is ignored, including writes to word 0 and the opening key, until reset.
- R4: While closed, writes to any word other than word 0 are dropped, and word 0 still decodes keys.
- R5: The configuration word (byte 0x04) takes written bits 27:20, 13:7 and 5:4. The other bits are forced: 31:28 read 3, 19:14 and 6 read 0, 3:2 read 3, and 1:0 read the size code (0, 1, 2, 3 for 256, 512, 1024, 2048 MiB).
- R6: A write to the PHY status word (byte 0x60) is stored with bit 0 cleared and bit 4 set.
- R7: A write to the ECC test word (byte 0x70) is stored with bit 12 set and bit 13 cleared.
- R8: Every other word in range stores the written value unchanged while the bank is open.
- R9: The word index is address bits 7:2, and address bits 1:0 are ignored. If any address bit above 7 is set, a read returns 0 and a write has no effect.
- R10: Reset zeroes all words and closes the bank. The configuration word then reads its forced fields with all writable bits zero.
- R11: rdata is loaded on the clock edge where rd_en is high and holds its value otherwise. It shows the stored state before that edge, so a write on the same edge becomes visible to the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The main function is the interaction between the key word and the shaping of stored words. It is tried with directed sequences and with a seeded random mix of keys, ordinary data, aliased low address bits and out-of-range addresses. Writes while closed and writes while sealed separate a gate that only checks "not open" from one that also ignores key writes. All-ones and all-zeros data on the configuration, PHY and ECC words expose any mask bit that is too wide or too narrow. A read and a write to the same word on one edge show whether the read path is registered from the old state. The test ends with a reset issued while the bank is sealed, which shows that only reset releases the seal.

// File: rtl/memctl_regbank_pkg.sv
package memctl_regbank_pkg;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_OPEN = 2'd1,
    LK_SEAL = 2'd2
  } lock_e;

  localparam logic [31:0] KEY_OPEN      = 32'hFC60_0309;
  localparam logic [31:0] KEY_SEAL      = 32'hDEAD_DEAD;
  localparam logic [31:0] PROT_VAL_OPEN = 32'h0000_0001;
  localparam logic [31:0] PROT_VAL_SEAL = 32'h0000_0010;
  localparam logic [31:0] PROT_VAL_SHUT = 32'h0000_0000;

  localparam int unsigned WORD_PROT = 0;
  localparam int unsigned WORD_CFG  = 1;
  localparam int unsigned WORD_PHY  = 24;
  localparam int unsigned WORD_ECC  = 28;

  // bits of the configuration word taken from the bus
  localparam logic [31:0] CFG_WR_MASK = 32'h0FF0_3FB0;
  localparam logic [3:0]  CFG_VER     = 4'd3;
  localparam logic [1:0]  CFG_APER    = 2'd3;

  localparam int unsigned PHY_IDLE_BIT = 0;
  localparam int unsigned PHY_PLL_BIT  = 4;
  localparam int unsigned ECC_DONE_BIT = 12;
  localparam int unsigned ECC_FAIL_BIT = 13;

  function automatic logic [1:0] size_code(int unsigned mib);
    case (mib)
      256:     return 2'd0;
      512:     return 2'd1;
      1024:    return 2'd2;
      2048:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] cfg_fixed(logic [1:0] code);
    return {CFG_VER, 24'h0, CFG_APER, code};
  endfunction

endpackage

// File: rtl/memctl_keygate.sv
module memctl_keygate
  import memctl_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_we,
  input  logic [31:0] key_data,
  output lock_e       lock_o,
  output logic [31:0] prot_word_o
);

  lock_e lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= LK_SHUT;
    end else if (key_we && lock_q != LK_SEAL) begin
      if (key_data == KEY_OPEN)      lock_q <= LK_OPEN;
      else if (key_data == KEY_SEAL) lock_q <= LK_SEAL;
      else                           lock_q <= LK_SHUT;
    end
  end

  always_comb begin
    case (lock_q)
      LK_OPEN: prot_word_o = PROT_VAL_OPEN;
      LK_SEAL: prot_word_o = PROT_VAL_SEAL;
      default: prot_word_o = PROT_VAL_SHUT;
    endcase
  end

  assign lock_o = lock_q;

  AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_q == LK_SEAL |=> lock_q == LK_SEAL); // R3
  AST_OPEN_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (rst)
    (lock_q != LK_OPEN && !(key_we && key_data == KEY_OPEN)) |=> lock_q != LK_OPEN); // R1
  AST_SEAL_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (rst)
    (lock_q != LK_SEAL && !(key_we && key_data == KEY_SEAL)) |=> lock_q != LK_SEAL); // R2

endmodule

// File: rtl/memctl_shaper.sv
module memctl_shaper
  import memctl_regbank_pkg::*;
#(
  parameter int unsigned IDX_W     = 6,
  parameter logic [1:0]  SIZE_CODE = 2'd2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      din,
  output logic [31:0]      dout
);

  localparam logic [IDX_W-1:0] I_CFG = IDX_W'(WORD_CFG);
  localparam logic [IDX_W-1:0] I_PHY = IDX_W'(WORD_PHY);
  localparam logic [IDX_W-1:0] I_ECC = IDX_W'(WORD_ECC);

  always_comb begin
    dout = din;
    if (idx == I_CFG) begin
      dout = (din & CFG_WR_MASK) | cfg_fixed(SIZE_CODE);
    end else if (idx == I_PHY) begin
      dout[PHY_IDLE_BIT] = 1'b0;
      dout[PHY_PLL_BIT]  = 1'b1;
    end else if (idx == I_ECC) begin
      dout[ECC_DONE_BIT] = 1'b1;
      dout[ECC_FAIL_BIT] = 1'b0;
    end
  end

endmodule

// File: rtl/memctl_store.sv
module memctl_store
  import memctl_regbank_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned IDX_W     = 6,
  parameter logic [31:0] CFG_RESET = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rword
);

  logic [31:0] mem [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [31:0] RST_VAL = (w == WORD_CFG) ? CFG_RESET : 32'h0;
    always_ff @(posedge clk) begin
      if (rst)                              mem[w] <= RST_VAL;
      else if (we && widx == IDX_W'(w))     mem[w] <= wdata;
    end
  end

  assign rword = mem[ridx];

  AST_PHY_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(WORD_PHY)) |=>
      (!mem[WORD_PHY][PHY_IDLE_BIT] && mem[WORD_PHY][PHY_PLL_BIT])); // R6
  AST_ECC_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(WORD_ECC)) |=>
      (mem[WORD_ECC][ECC_DONE_BIT] && !mem[WORD_ECC][ECC_FAIL_BIT])); // R7
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mem[WORD_CFG])); // R4

endmodule

// File: rtl/memctl_regbank.sv
module memctl_regbank
  import memctl_regbank_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DRAM_MIB  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
  localparam logic [1:0]  SIZE_CODE = size_code(DRAM_MIB);
  localparam logic [31:0] CFG_RESET = cfg_fixed(SIZE_CODE);

  initial begin
    AST_PARAM_OK: assert (NUM_WORDS > WORD_ECC && ADDR_W > IDX_W + 2 &&
      (DRAM_MIB == 256 || DRAM_MIB == 512 || DRAM_MIB == 1024 || DRAM_MIB == 2048)); // R5
  end

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             key_we;
  logic             store_we;
  lock_e            lock;
  logic [31:0]      prot_word;
  logic [31:0]      shaped;
  logic [31:0]      rword;
  logic [1:0]       unused_lsb;

  assign unused_lsb = addr[1:0];
  assign idx        = addr[IDX_W+1:2];
  assign in_range   = (addr[ADDR_W-1:IDX_W+2] == '0);
  assign key_we     = wr_en && in_range && idx == IDX_W'(WORD_PROT);
  assign store_we   = wr_en && in_range && idx != IDX_W'(WORD_PROT) && lock == LK_OPEN;

  memctl_keygate u_keygate (
    .clk        (clk),
    .rst        (rst),
    .key_we     (key_we),
    .key_data   (wdata),
    .lock_o     (lock),
    .prot_word_o(prot_word)
  );

  memctl_shaper #(.IDX_W(IDX_W), .SIZE_CODE(SIZE_CODE)) u_shaper (
    .idx (idx),
    .din (wdata),
    .dout(shaped)
  );

  memctl_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CFG_RESET(CFG_RESET)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (store_we),
    .widx (idx),
    .wdata(shaped),
    .ridx (idx),
    .rword(rword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!in_range)                         rdata <= '0;
      else if (idx == IDX_W'(WORD_PROT))     rdata <= prot_word;
      else                                   rdata <= rword;
    end
  end

  AST_CFG_READ_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(addr) == ADDR_W'(4 * WORD_CFG)) |->
      (rdata[31:28] == CFG_VER && rdata[19:14] == 6'd0 && !rdata[6] &&
       rdata[3:2] == CFG_APER && rdata[1:0] == SIZE_CODE)); // R5
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(addr[ADDR_W-1:IDX_W+2]) != '0) |->
      rdata == 32'h0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R11

endmodule

// File: tb/test_memctl_regbank.sv
module test_memctl_regbank;

  localparam int unsigned NW   = 64;
  localparam int unsigned AW   = 12;
  localparam int unsigned MIB  = 1024;
  localparam logic [31:0] K_OPEN = 32'hFC60_0309;
  localparam logic [31:0] K_SEAL = 32'hDEAD_DEAD;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mdl [NW];
  int          mlock;   // 0 closed, 1 open, 2 sealed

  always #4 clk = ~clk;

  memctl_regbank #(.NUM_WORDS(NW), .ADDR_W(AW), .DRAM_MIB(MIB)) i_memctl_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] cfg_expect(logic [31:0] d);
    logic [31:0] r;
    r = d;
    r[31:28] = 4'd3;
    r[19:14] = 6'd0;
    r[6]     = 1'b0;
    r[3:2]   = 2'd3;
    r[1:0]   = (MIB == 256) ? 2'd0 : (MIB == 512) ? 2'd1 : (MIB == 1024) ? 2'd2 : 2'd3;
    return r;
  endfunction

  function automatic logic [31:0] shape_expect(int w, logic [31:0] d);
    logic [31:0] r;
    r = d;
    if (w == 1) r = cfg_expect(d);
    if (w == 24) begin r[0] = 1'b0; r[4] = 1'b1; end
    if (w == 28) begin r[12] = 1'b1; r[13] = 1'b0; end
    return r;
  endfunction

  function automatic logic [31:0] read_expect(logic [AW-1:0] a);
    if (a[AW-1:8] != '0) return 32'h0;
    if (a[7:2] == 0) return (mlock == 1) ? 32'h1 : (mlock == 2) ? 32'h10 : 32'h0;
    return mdl[a[7:2]];
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [31:0] d);
    int w;
    if (a[AW-1:8] != '0 || mlock == 2) return;
    w = a[7:2];
    if (w == 0) mlock = (d == K_OPEN) ? 1 : (d == K_SEAL) ? 2 : 0;
    else if (mlock == 1) mdl[w] = shape_expect(w, d);
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NW; i++) mdl[i] = 32'h0;
    mdl[1] = cfg_expect(32'h0);
    mlock  = 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(string req, logic [AW-1:0] a);
    logic [31:0] e;
    @(negedge clk);
    e = read_expect(a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_dummy;
    logic [31:0] hold;
    seed_dummy = $urandom(32'd20240611);
    do_reset();

    // R10: reset contents
    do_read("R10 prot", 12'h000);
    check("R10 prot literal", rdata, 32'h0);
    do_read("R10 cfg", 12'h004);
    check("R10 cfg literal", rdata, 32'h3000_000E);
    do_read("R10 phy", 12'h060);
    do_read("R10 word 9", 12'h024);

    // R4: closed drops writes, key word still decodes
    do_write(12'h024, 32'hA5A5_5A5A);
    do_read("R4 closed drop", 12'h024);
    check("R4 closed literal", rdata, 32'h0);

    // R1: open
    do_write(12'h000, K_OPEN);
    do_read("R1 prot open", 12'h000);
    check("R1 prot literal", rdata, 32'h1);
    do_write(12'h024, 32'hA5A5_5A5A);
    do_read("R1 write stored", 12'h024);

    // R5: configuration masking
    do_write(12'h004, 32'hFFFF_FFFF);
    do_read("R5 cfg ones", 12'h004);
    check("R5 cfg ones literal", rdata, 32'h3FF0_3FBE);
    do_write(12'h004, 32'h0000_0000);
    do_read("R5 cfg zeros", 12'h004);

    // R6, R7, R8
    do_write(12'h060, 32'hFFFF_FFFF);
    do_read("R6 phy ones", 12'h060);
    check("R6 phy literal", rdata, 32'hFFFF_FFFE);
    do_write(12'h060, 32'h0000_0001);
    do_read("R6 phy busy", 12'h060);
    do_write(12'h070, 32'hFFFF_FFFF);
    do_read("R7 ecc ones", 12'h070);
    check("R7 ecc literal", rdata, 32'hFFFF_DFFF);
    do_write(12'h070, 32'h0);
    do_read("R7 ecc zeros", 12'h070);
    do_write(12'h0FC, 32'h1234_5678);
    do_read("R8 top word", 12'h0FC);

    // R9: aliasing and out of range
    do_write(12'h02B, 32'hCAFE_F00D);
    do_read("R9 low bits ignored", 12'h028);
    do_write(12'h104, 32'hFFFF_FFFF);
    do_read("R9 oor write ignored", 12'h004);
    do_read("R9 oor read zero", 12'h104);
    do_read("R9 oor read high", 12'h800);

    // R11: read and write same word on one edge; hold when rd_en low
    @(negedge clk);
    hold = read_expect(12'h0FC);
    wr_en = 1'b1; rd_en = 1'b1; addr = 12'h0FC; wdata = 32'h0BAD_BEEF;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(12'h0FC, 32'h0BAD_BEEF);
    check("R11 old value", rdata, hold);
    addr = 12'h024;
    repeat (2) @(negedge clk);
    check("R11 hold", rdata, hold);
    do_read("R11 new value", 12'h0FC);

    // R2: other value closes
    do_write(12'h000, 32'h0000_0001);
    do_read("R2 closed by other", 12'h000);
    check("R2 closed literal", rdata, 32'h0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [AW-1:0] a;
      logic [31:0] d;
      sel = $urandom_range(0, 15);
      case (sel % 5)
        0: a = 12'h000;
        1: a = 12'h004;
        2: a = 12'h060;
        3: a = 12'h070;
        default: a = AW'({$urandom_range(0, 63), 2'b00});
      endcase
      a[1:0] = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) a[AW-1:8] = 4'($urandom_range(1, 15));
      d = $urandom();
      if (a[7:2] == 0) begin
        if ($urandom_range(0, 2) != 0) d = K_OPEN;
        else if ($urandom_range(0, 40) == 0) d = K_SEAL;
      end
      if ($urandom_range(0, 1) == 0) do_write(a, d);
      else do_read("R8 random", a);
    end

    // R3: sealed ignores everything
    do_write(12'h000, K_OPEN);
    do_write(12'h010, 32'h5555_AAAA);
    do_write(12'h000, K_SEAL);
    do_read("R2 sealed value", 12'h000);
    check("R2 sealed literal", rdata, 32'h10);
    do_write(12'h000, K_OPEN);
    do_read("R3 key ignored", 12'h000);
    check("R3 key literal", rdata, 32'h10);
    do_write(12'h010, 32'h1111_2222);
    do_read("R3 data ignored", 12'h010);
    check("R3 data literal", rdata, 32'h5555_AAAA);

    // R10: reset releases the seal
    do_reset();
    do_read("R10 after seal", 12'h000);
    do_read("R10 word cleared", 12'h010);
    check("R10 word literal", rdata, 32'h0);
    do_write(12'h000, K_OPEN);
    do_read("R10 reopen", 12'h000);

    finish_run();
  end

endmodule